// File: doc/BRIEF.md
# Tagged Multi-Line Receive Silo

This block is the shared receive buffer of a sixteen-line serial multiplexer. Each line's receiver stores a finished character into a single common FIFO. Every stored entry carries the number of the line it came from and the error conditions seen on that character. The receivers are modelled as one write strobe carrying a line number, a character, and parity and framing error bits.

The processor drains the buffer through a read port. The oldest entry is always visible on that port, and each read strobe removes exactly one entry. The top bit of the word is set while the word holds a character, so the word reads as negative while data is present. A control word holds two interrupts, each with its own enable:
- a receive flag that follows "buffer not empty";
- a storage flag that rises when the fill level reaches a programmable alarm level.

A master-clear bit in the control word flushes the buffer and the flags.

If a character arrives while the buffer is full, that character is lost. The next character stored for the same line carries an overrun mark.

Top module: `rx_silo`

## Requirements
- R1: The read word is laid out as follows: bit 15 = valid, bit 14 = overrun, bit 13 = framing error, bit 12 = parity error, bits 11:8 = line number, bits 7:0 = character.
- R2: Entries leave in arrival order. `rd_word` shows the oldest entry, and each `rd_stb` on a non-empty buffer removes exactly that one entry at the next clock edge.
- R3: While the buffer is empty, `rd_word` is 16'h0000. A read strobe on an empty buffer changes nothing.
- R4: The buffer holds at most 64 entries. A write that arrives when 64 entries are held, and that is not paired with a pop in the same cycle, is discarded.
- R5: After a discarded write on line L, the next entry stored for line L has bit 14 set. Entries for the other lines, and later entries for line L, have bit 14 clear unless another discard happens.
- R6: A write and a pop in the same cycle leave the fill level unchanged. This also holds when the buffer is full, in which case the write is accepted.
- R7: Control bit 7 (the receive flag) reads 1 exactly when the buffer is non-empty. `irq_rx` equals control bit 7 AND control bit 6 (the receive enable).
- R8: Control bit 14 (the storage flag) is set on the clock edge that follows any cycle with a non-zero fill level at or above the alarm level. A control write with bit 14 = 0 clears the flag, but setting wins when both happen in the same cycle. `irq_store` equals bit 14 AND bit 12 (the storage enable). Every other control read bit is 0.
- R9: A control write with bit 11 = 1 is a master clear. At the next edge the buffer is empty, both flags and all pending overrun marks are cleared, the enables load bits 6 and 12 of that word, and any same-cycle write or read is ignored. The alarm level keeps its value.
- R10: After reset, all outputs are zero. `alm_rdata` returns the last value written through `alm_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | A received character is offered this cycle |
| wr_line | input | 4 | Line number of the offered character |
| wr_char | input | 8 | Character data |
| wr_perr | input | 1 | Parity error on this character |
| wr_ferr | input | 1 | Framing error (break) on this character |
| rd_stb | input | 1 | Pop the oldest entry |
| rd_word | output | 16 | Oldest entry in read format, or zero when empty |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 16 | Control write data |
| ctl_rdata | output | 16 | Control word: flags and enables |
| alm_wr | input | 1 | Write strobe for the alarm level |
| alm_wdata | input | 7 | New alarm level |
| alm_rdata | output | 7 | Current alarm level |
| irq_rx | output | 1 | Receive interrupt request |
| irq_store | output | 1 | Storage (alarm) interrupt request |

## Verification
The two functions that most often fall in the same cycle are a receiver write and a processor pop. The hardest case is at the full boundary, where the pop must make room for the write rather than cause an overrun. The bench fills the buffer to 64 entries, then issues a write and a pop together. It judges the result by draining the buffer: the written character must appear in its place and no overrun mark may appear. A master clear written in the same cycle as a write and a pop is also provoked, and nothing may survive it. A long random phase then mixes writes, pops, alarm changes and flag clears, and compares every output against a queue-based model on every clock.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int TAG_W  = 4;
  localparam int CHAR_W = 8;
  localparam int LVL_W  = 8;

  localparam int B_SI  = 14;
  localparam int B_SIE = 12;
  localparam int B_MC  = 11;
  localparam int B_RI  = 7;
  localparam int B_RIE = 6;

  typedef struct packed {
    logic              ovr;
    logic              ferr;
    logic              perr;
    logic [TAG_W-1:0]  line;
    logic [CHAR_W-1:0] ch;
  } entry_t;

  // Read-side word: valid marker on top, all zero when nothing is held.
  function automatic logic [15:0] word_of(input logic valid, input entry_t e);
    return valid ? {1'b1, e} : 16'h0000;
  endfunction

  // Alarm condition: some data held and the level has reached the threshold.
  function automatic logic alarm_hit(input logic [LVL_W-1:0] lvl,
                                     input logic [LVL_W-1:0] alm);
    return (lvl != '0) && (lvl >= alm);
  endfunction

  function automatic logic [15:0] ctl_word(input logic si, input logic sie,
                                           input logic ri, input logic rie);
    logic [15:0] w;
    w        = '0;
    w[B_SI]  = si;
    w[B_SIE] = sie;
    w[B_RI]  = ri;
    w[B_RIE] = rie;
    return w;
  endfunction
endpackage

// File: rtl/rxs_store.sv
module rxs_store #(
  parameter int DEPTH = 64,
  parameter int EW    = 15,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [EW-1:0] wentry,
  output logic [EW-1:0] head,
  output logic [CW-1:0] level
);
  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wp] <= wentry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      unique case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign head = mem[rp];
endmodule

// File: rtl/rxs_ovr.sv
module rxs_ovr #(
  parameter int NLINES = 16,
  localparam int LW    = $clog2(NLINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          drop,
  input  logic          accept,
  input  logic [LW-1:0] line,
  output logic          pend_sel
);
  logic [NLINES-1:0] pend;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             pend[i] <= 1'b0;
      else if (clr)                           pend[i] <= 1'b0;
      else if (drop && line == LW'(i))        pend[i] <= 1'b1;
      else if (accept && line == LW'(i))      pend[i] <= 1'b0;
    end
  end

  assign pend_sel = pend[line];
endmodule

// File: rtl/rxs_ctl.sv
module rxs_ctl #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [15:0]   ctl_wdata,
  input  logic          alm_wr,
  input  logic [CW-1:0] alm_wdata,
  input  logic          hit,
  output logic          mc,
  output logic          rie,
  output logic          sie,
  output logic          si,
  output logic [CW-1:0] alarm
);
  import rxs_pkg::*;

  assign mc = ctl_wr && ctl_wdata[B_MC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rie   <= 1'b0;
      sie   <= 1'b0;
      si    <= 1'b0;
      alarm <= '0;
    end else begin
      if (alm_wr) alarm <= alm_wdata;
      if (ctl_wr) begin
        rie <= ctl_wdata[B_RIE];
        sie <= ctl_wdata[B_SIE];
      end
      if (mc)                            si <= 1'b0;
      else if (hit)                      si <= 1'b1;
      else if (ctl_wr && !ctl_wdata[B_SI]) si <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_silo.sv
module rx_silo #(
  parameter int NLINES = 16,
  parameter int DEPTH  = 64,
  localparam int LW    = $clog2(NLINES),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [LW-1:0] wr_line,
  input  logic [7:0]    wr_char,
  input  logic          wr_perr,
  input  logic          wr_ferr,
  input  logic          rd_stb,
  output logic [15:0]   rd_word,
  input  logic          ctl_wr,
  input  logic [15:0]   ctl_wdata,
  output logic [15:0]   ctl_rdata,
  input  logic          alm_wr,
  input  logic [CW-1:0] alm_wdata,
  output logic [CW-1:0] alm_rdata,
  output logic          irq_rx,
  output logic          irq_store
);
  import rxs_pkg::*;
  localparam int EW = $bits(entry_t);

  logic          mc, rie, sie, si, hit, pend_sel;
  logic          full, empty, pop_ok, push_ok, drop;
  logic [CW-1:0] level, alarm;
  logic [EW-1:0] head_bits;
  entry_t        in_entry, head;

  assign full    = (level == CW'(DEPTH));
  assign empty   = (level == '0);
  assign pop_ok  = rd_stb && !empty && !mc;
  assign push_ok = wr_stb && !mc && (!full || pop_ok);
  assign drop    = wr_stb && !mc && full && !pop_ok;
  assign hit     = alarm_hit(LVL_W'(level), LVL_W'(alarm));

  assign in_entry = '{ovr: pend_sel, ferr: wr_ferr, perr: wr_perr,
                      line: TAG_W'(wr_line), ch: wr_char};

  rxs_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(mc), .push(push_ok), .pop(pop_ok),
    .wentry(in_entry), .head(head_bits), .level(level)
  );

  rxs_ovr #(.NLINES(NLINES)) u_ovr (
    .clk(clk), .rst_n(rst_n), .clr(mc), .drop(drop), .accept(push_ok),
    .line(wr_line), .pend_sel(pend_sel)
  );

  rxs_ctl #(.CW(CW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .alm_wr(alm_wr), .alm_wdata(alm_wdata), .hit(hit), .mc(mc),
    .rie(rie), .sie(sie), .si(si), .alarm(alarm)
  );

  assign head      = entry_t'(head_bits);
  assign rd_word   = word_of(!empty, head);
  assign ctl_rdata = ctl_word(si, sie, !empty, rie);
  assign alm_rdata = alarm;
  assign irq_rx    = !empty && rie;
  assign irq_store = si && sie;
endmodule

// File: rtl/rx_silo_chk.sv
module rx_silo_chk #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_stb,
  input logic          rd_stb,
  input logic [15:0]   rd_word,
  input logic [15:0]   ctl_rdata,
  input logic [CW-1:0] level,
  input logic          push_ok,
  input logic          pop_ok,
  input logic          mc,
  input logic          hit
);
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

  a_r3_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_word[15] |-> rd_word == 16'h0000);

  a_r3_empty_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rd_word[15] && !wr_stb && !mc) |=> !rd_word[15]);

  a_r7_ri_follows_data: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[7] == rd_word[15]);

  a_r6_push_pop_level: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> $stable(level));

  a_r8_alarm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !mc) |=> ctl_rdata[14]);

  a_r9_master_clear: assert property (@(posedge clk) disable iff (!rst_n)
    mc |=> (level == '0 && !ctl_rdata[14] && !ctl_rdata[7]));
endmodule

bind rx_silo rx_silo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
  .rd_word(rd_word), .ctl_rdata(ctl_rdata), .level(level),
  .push_ok(push_ok), .pop_ok(pop_ok), .mc(mc), .hit(hit)
);

// File: tb/sim_rx_silo.sv
`timescale 1ns/1ps
module sim_rx_silo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 0, wr_perr = 0, wr_ferr = 0, rd_stb = 0;
  logic [3:0]  wr_line = 0;
  logic [7:0]  wr_char = 0;
  logic        ctl_wr = 0, alm_wr = 0;
  logic [15:0] ctl_wdata = 0;
  logic [6:0]  alm_wdata = 0;
  logic [15:0] rd_word, ctl_rdata;
  logic [6:0]  alm_rdata;
  logic        irq_rx, irq_store;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural reference
  logic [15:0] q[$];
  bit          pend[16];
  bit          m_si, m_sie, m_rie;
  int          m_alm;

  always #10 clk = ~clk;

  rx_silo u0 (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_line(wr_line),
    .wr_char(wr_char), .wr_perr(wr_perr), .wr_ferr(wr_ferr),
    .rd_stb(rd_stb), .rd_word(rd_word), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .alm_wr(alm_wr),
    .alm_wdata(alm_wdata), .alm_rdata(alm_rdata), .irq_rx(irq_rx),
    .irq_store(irq_store)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    int cnt = q.size();
    bit mc  = ctl_wr && ctl_wdata[11];
    bit hit = (cnt != 0) && (cnt >= m_alm);
    bit pop, acc;
    if (alm_wr) m_alm = alm_wdata;
    if (mc) begin
      q.delete();
      foreach (pend[i]) pend[i] = 0;
      m_si = 0; m_rie = ctl_wdata[6]; m_sie = ctl_wdata[12];
    end else begin
      pop = rd_stb && cnt > 0;
      acc = wr_stb && (cnt < 64 || pop);
      if (pop) void'(q.pop_front());
      if (acc) begin
        q.push_back({1'b1, pend[wr_line], wr_ferr, wr_perr, wr_line, wr_char});
        pend[wr_line] = 0;
      end else if (wr_stb) pend[wr_line] = 1;
      if (hit) m_si = 1;
      else if (ctl_wr && !ctl_wdata[14]) m_si = 0;
      if (ctl_wr) begin m_rie = ctl_wdata[6]; m_sie = ctl_wdata[12]; end
    end
  endtask

  task automatic compare();
    logic [15:0] ew = (q.size() != 0) ? q[0] : 16'h0;
    bit ri = q.size() != 0;
    logic [15:0] ec = 16'h0;
    ec[14] = m_si; ec[12] = m_sie; ec[7] = ri; ec[6] = m_rie;
    chk(rd_word === ew, "R2 rd_word", rd_word, ew);
    chk(ctl_rdata[7] === ri, "R7 receive flag", ctl_rdata[7], ri);
    chk(irq_rx === (ri && m_rie), "R7 irq_rx", irq_rx, ri && m_rie);
    chk(ctl_rdata === ec, "R8 control word", ctl_rdata, ec);
    chk(irq_store === (m_si && m_sie), "R8 irq_store", irq_store, m_si && m_sie);
    chk(alm_rdata === 7'(m_alm), "R10 alarm readback", alm_rdata, m_alm);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    wr_stb = 0; rd_stb = 0; ctl_wr = 0; alm_wr = 0; wr_perr = 0; wr_ferr = 0;
  endtask

  task automatic push(input int ln, input int ch, input bit pe, input bit fe);
    idle();
    wr_stb = 1; wr_line = 4'(ln); wr_char = 8'(ch); wr_perr = pe; wr_ferr = fe;
    step();
    idle();
  endtask

  task automatic pop1();
    idle(); rd_stb = 1; step(); idle();
  endtask

  task automatic ctl(input logic [15:0] w);
    idle(); ctl_wr = 1; ctl_wdata = w; step(); idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m_si = 0; m_sie = 0; m_rie = 0; m_alm = 0;
    foreach (pend[i]) pend[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R10: reset state
    chk(rd_word == 0 && ctl_rdata == 0 && !irq_rx && !irq_store && alm_rdata == 0,
        "R10 reset state", {ctl_rdata, rd_word}, 0);

    idle(); alm_wr = 1; alm_wdata = 7'd16; step(); idle();
    chk(alm_rdata == 7'd16, "R10 alarm write", alm_rdata, 16);
    ctl(16'h1040);

    // R1: entry format
    push(5, 8'hA5, 1, 0);
    chk(rd_word == 16'h95A5, "R1 parity entry", rd_word, 16'h95A5);
    push(3, 8'h00, 0, 1);
    chk(rd_word == 16'h95A5, "R2 oldest stays at head", rd_word, 16'h95A5);
    pop1();
    chk(rd_word == 16'hA300, "R1 framing entry", rd_word, 16'hA300);
    pop1();
    // R3: empty read
    chk(rd_word == 16'h0000, "R3 empty word", rd_word, 0);
    pop1();
    chk(rd_word == 16'h0000 && !ctl_rdata[7], "R3 empty read no effect", rd_word, 0);
    push(1, 8'h11, 0, 0);
    chk(rd_word == 16'h8111, "R3 state intact after empty read", rd_word, 16'h8111);
    pop1();

    // R4 / R5 / R6 around the full boundary
    for (int i = 0; i < 64; i++) push(i % 16, i, 0, 0);
    chk(ctl_rdata[14] == 1'b1, "R8 alarm set when filled", ctl_rdata[14], 1);
    push(7, 8'hEE, 0, 0);
    chk(rd_word == 16'h8000, "R4 full write discarded", rd_word, 16'h8000);
    ctl(16'h1040);
    chk(ctl_rdata[14] == 1'b1, "R8 set wins over clear", ctl_rdata[14], 1);
    idle(); wr_stb = 1; wr_line = 4'd2; wr_char = 8'h22; rd_stb = 1; step(); idle();
    chk(rd_word == 16'h8101, "R6 pop at full", rd_word, 16'h8101);
    pop1(); pop1();
    push(9, 8'h99, 0, 0);
    push(7, 8'h77, 0, 0);
    for (int i = 0; i < 61; i++) pop1();
    chk(rd_word == 16'h8222, "R6 write accepted at full with pop", rd_word, 16'h8222);
    pop1();
    chk(rd_word == 16'h8999, "R5 other line unmarked", rd_word, 16'h8999);
    pop1();
    chk(rd_word == 16'hC777, "R5 overrun mark on line 7", rd_word, 16'hC777);
    pop1();
    ctl(16'h1040);
    chk(ctl_rdata[14] == 1'b0 && !irq_store, "R8 flag cleared when below", ctl_rdata[14], 0);

    // R9: master clear against a write and a pop in the same cycle
    push(4, 8'h44, 0, 0);
    push(6, 8'h66, 0, 0);
    idle(); ctl_wr = 1; ctl_wdata = 16'h0840; wr_stb = 1; wr_line = 4'd8;
    wr_char = 8'h88; rd_stb = 1; step(); idle();
    chk(rd_word == 0 && ctl_rdata == 16'h0040 && alm_rdata == 7'd16,
        "R9 master clear", {ctl_rdata, rd_word}, 32'h00400000);

    // random mix, compared every clock
    for (int n = 0; n < 4000; n++) begin
      idle();
      wr_stb  = ($urandom % 3) != 0;
      wr_line = 4'($urandom);
      wr_char = 8'($urandom);
      wr_perr = ($urandom % 5) == 0;
      wr_ferr = ($urandom % 7) == 0;
      rd_stb  = ($urandom % (n < 2000 ? 4 : 2)) == 0;
      if (($urandom % 40) == 0) begin
        ctl_wr = 1;
        ctl_wdata = 16'($urandom) & 16'hF7FF;
        if (($urandom % 4) == 0) ctl_wdata[11] = 1'b1;
      end
      if (($urandom % 60) == 0) begin alm_wr = 1; alm_wdata = 7'($urandom % 70); end
      step();
    end
    idle();
    finish_run();
  end
endmodule